// File: doc/BRIEF.md
# Three-Link Deflection Packet Router

A single switching node with three bidirectional links and no packet storage. Each cycle up to three packets arrive, one per incoming link. Every packet that arrives leaves the node in the next clock cycle, either on one of the three outgoing links or on a local delivery port. A programmable routing table maps each destination address to the preferred outgoing link.

When two packets want the same link, the one with the higher priority field gets it. The loser is sent out on a free link anyway ("deflected"), and its priority is raised by one, so a packet that keeps losing gains the right of way over time. When the node is congested (the number of arriving packets reaches a threshold), packets skip the table entirely. Each one is passed to the next link in a fixed rotation, and its priority is raised.

A packet is a word laid out, from the most significant bit down, as priority (PRIO_W bits), destination (DEST_W bits) and payload (DATA_W bits). With the defaults (PRIO_W=3, DEST_W=4, DATA_W=8, NODE_ID=5, CONG_THRESH=3), a 15-bit packet written in hex as 0xPDLL has priority P, destination D and payload LL.

Top module: `defl_router`

## Requirements
- R1: Packets presented on in_vld/in_pkt at a rising clock edge appear on the outputs after that edge and stay there until the next one, so the latency is one cycle. A packet lane that is not valid outputs all zeros.
- R2: Outside congestion, a packet not addressed to the node leaves on the link stored in the table for its destination, provided no stronger packet holds that link. Its priority is not changed in that case.
- R3: Packets are served in descending priority order. When priorities are equal, the lower input index goes first, with input 0 highest.
- R4: Outside congestion, a packet whose preferred link is already taken leaves on the lowest-numbered link still free, and its priority is incremented.
- R5: The priority increment saturates at the all-ones value; it never wraps to zero.
- R6: A packet whose destination equals NODE_ID leaves on the eject port with its priority unchanged. At most one packet is ejected per cycle, chosen by the R3 order. Any other local packet is handled as deflected: it goes to the lowest free link outside congestion, or rotates during congestion, and its priority is incremented.
- R7: When the count of valid inputs is at least CONG_THRESH, every non-ejected packet from input k leaves on link (k+1) mod 3 with its priority incremented, whatever the table holds.
- R8: Every valid input packet leaves on exactly one output: one of the links or the eject port.
- R9: Asserting tbl_we writes tbl_link into the entry for tbl_dest. The new entry steers packets from the following cycle onward, while a packet arriving in the write cycle uses the old entry. A write whose tbl_link value is 3 is ignored.
- R10: While rst is high, all outputs are zero. On reset, every table entry returns to link 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 3 | Valid flag per incoming link |
| in_pkt | input | 3 x PKT_W | Packet per incoming link |
| out_vld | output | 3 | Valid flag per outgoing link |
| out_pkt | output | 3 x PKT_W | Packet per outgoing link |
| eject_vld | output | 1 | Local delivery valid |
| eject_pkt | output | PKT_W | Local delivery packet |
| tbl_we | input | 1 | Routing table write enable |
| tbl_dest | input | DEST_W | Table entry to write |
| tbl_link | input | 2 | Link number to store (0 to 2) |

## Verification
Local delivery and deflection can occur in the same cycle. When two packets addressed to the node arrive together, one takes the eject port and the other must be deflected onto a link with its priority raised. The bench provokes this both in normal operation and under congestion. It judges the result by which packet ejects, which link the loser takes, and the loser's new priority. It also issues a table write in the same cycle as a packet using that entry, and checks that the old entry steers that packet and the new entry steers the next one.

// File: rtl/dn_pkg.sv
package dn_pkg;
   localparam int unsigned LINKS = 3;
   localparam int unsigned LW    = 2;
   typedef logic [LW-1:0] link_t;

   // next link in the congestion rotation
   function automatic link_t rot_next(input link_t k);
      return (k == link_t'(LINKS - 1)) ? link_t'(0) : link_t'(k + 1'b1);
   endfunction
endpackage

// File: rtl/dn_route_table.sv
module dn_route_table
   import dn_pkg::*;
#(
   parameter int unsigned DEST_W = 4
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          wr_en,
   input  logic [DEST_W-1:0]             wr_dest,
   input  logic [LW-1:0]                 wr_link,
   input  logic [LINKS-1:0][DEST_W-1:0]  lk_dest,
   output logic [LINKS-1:0][LW-1:0]      lk_link
);
   localparam int unsigned DEPTH = 1 << DEST_W;

   logic [LW-1:0] ent [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int e = 0; e < DEPTH; e++) ent[e] <= '0;
      end else if (wr_en && (wr_link < LW'(LINKS))) begin
         ent[wr_dest] <= wr_link;
      end
   end

   for (genvar k = 0; k < LINKS; k++) begin : g_lookup
      assign lk_link[k] = ent[lk_dest[k]];
   end

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent_chk
      // R9
      entry_in_range_chk: assert property (@(posedge clk) disable iff (rst)
         ent[e] < LW'(LINKS));
   end
endmodule

// File: rtl/dn_rank.sv
module dn_rank
   import dn_pkg::*;
#(
   parameter int unsigned PRIO_W = 3
) (
   input  logic [LINKS-1:0]              in_v,
   input  logic [LINKS-1:0][PRIO_W-1:0]  prio,
   output logic [LINKS-1:0][LW-1:0]      ord
);
   localparam int unsigned KW = PRIO_W + 1;

   logic [LINKS-1:0][KW-1:0] key;
   logic [LINKS-1:0][LW-1:0] rank;

   for (genvar k = 0; k < LINKS; k++) begin : g_key
      assign key[k] = {in_v[k], prio[k]};
   end

   // rank of a port = how many other ports precede it
   always_comb begin
      for (int i = 0; i < LINKS; i++) begin
         rank[i] = '0;
         for (int j = 0; j < LINKS; j++) begin
            if (j != i) begin
               if ((key[j] > key[i]) || ((key[j] == key[i]) && (j < i)))
                  rank[i] = rank[i] + 1'b1;
            end
         end
      end
   end

   always_comb begin
      ord = '0;
      for (int i = 0; i < LINKS; i++) ord[rank[i]] = LW'(i);
   end
endmodule

// File: rtl/dn_alloc.sv
module dn_alloc
   import dn_pkg::*;
#(
   parameter int unsigned DEST_W  = 4,
   parameter int unsigned NODE_ID = 5
) (
   input  logic [LINKS-1:0]              in_v,
   input  logic [LINKS-1:0][DEST_W-1:0]  dest,
   input  logic [LINKS-1:0][LW-1:0]      pref,
   input  logic [LINKS-1:0][LW-1:0]      ord,
   input  logic                          cong,
   output logic [LINKS-1:0]              out_v,
   output logic [LINKS-1:0][LW-1:0]      out_src,
   output logic [LINKS-1:0]              out_bump,
   output logic                          ej_v,
   output logic [LW-1:0]                 ej_src
);
   localparam logic [DEST_W-1:0] SELF = DEST_W'(NODE_ID);

   always_comb begin
      logic [LW-1:0] s;
      logic [LW-1:0] o;
      logic          placed;
      out_v    = '0;
      out_src  = '0;
      out_bump = '0;
      ej_v     = 1'b0;
      ej_src   = '0;
      s        = '0;
      o        = '0;
      placed   = 1'b0;
      for (int r = 0; r < LINKS; r++) begin
         s = ord[r];
         if (in_v[s]) begin
            if ((dest[s] == SELF) && !ej_v) begin
               ej_v   = 1'b1;
               ej_src = s;
            end else if (cong) begin
               o           = rot_next(s);
               out_v[o]    = 1'b1;
               out_src[o]  = s;
               out_bump[o] = 1'b1;
            end else if ((dest[s] != SELF) && (pref[s] < LW'(LINKS))
                         && !out_v[pref[s]]) begin
               out_v[pref[s]]   = 1'b1;
               out_src[pref[s]] = s;
            end else begin
               placed = 1'b0;
               for (int f = 0; f < LINKS; f++) begin
                  if (!placed && !out_v[f]) begin
                     out_v[f]    = 1'b1;
                     out_src[f]  = s;
                     out_bump[f] = 1'b1;
                     placed      = 1'b1;
                  end
               end
            end
         end
      end
   end
endmodule

// File: rtl/defl_router.sv
module defl_router
   import dn_pkg::*;
#(
   parameter int unsigned DEST_W      = 4,
   parameter int unsigned PRIO_W      = 3,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned NODE_ID     = 5,
   parameter int unsigned CONG_THRESH = 3,
   localparam int unsigned PKT_W      = PRIO_W + DEST_W + DATA_W
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic [2:0]                   in_vld,
   input  logic [2:0][PKT_W-1:0]        in_pkt,
   output logic [2:0]                   out_vld,
   output logic [2:0][PKT_W-1:0]        out_pkt,
   output logic                         eject_vld,
   output logic [PKT_W-1:0]             eject_pkt,
   input  logic                         tbl_we,
   input  logic [DEST_W-1:0]            tbl_dest,
   input  logic [1:0]                   tbl_link
);
   // elaboration-time parameter checks
   if (DEST_W < 1 || DEST_W > 10) begin : g_bad_dest
      $error("DEST_W must lie in 1..10");
   end
   if (PRIO_W < 1) begin : g_bad_prio
      $error("PRIO_W must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be at least 1");
   end
   if (NODE_ID >= (1 << DEST_W)) begin : g_bad_id
      $error("NODE_ID must fit in DEST_W bits");
   end
   if (CONG_THRESH < 1) begin : g_bad_cong
      $error("CONG_THRESH must be at least 1");
   end

   localparam int unsigned CW = 2;

   logic [LINKS-1:0][PRIO_W-1:0] f_prio;
   logic [LINKS-1:0][DEST_W-1:0] f_dest;
   logic [LINKS-1:0][LW-1:0]     pref;
   logic [LINKS-1:0][LW-1:0]     ord;
   logic [LINKS-1:0]             a_v;
   logic [LINKS-1:0][LW-1:0]     a_src;
   logic [LINKS-1:0]             a_bump;
   logic                         a_ej;
   logic [LW-1:0]                a_ej_src;
   logic                         cong;
   logic [CW-1:0]                nvalid;

   for (genvar k = 0; k < LINKS; k++) begin : g_fields
      assign f_prio[k] = in_pkt[k][PKT_W-1 -: PRIO_W];
      assign f_dest[k] = in_pkt[k][DATA_W +: DEST_W];
   end

   assign nvalid = CW'(in_vld[0]) + CW'(in_vld[1]) + CW'(in_vld[2]);

   // congestion detector: removed entirely when the threshold is unreachable
   if (CONG_THRESH > LINKS) begin : g_no_cong
      assign cong = 1'b0;
   end else begin : g_cong
      assign cong = (nvalid >= CW'(CONG_THRESH));
   end

   dn_route_table #(.DEST_W(DEST_W)) u_tbl (
      .clk(clk), .rst(rst),
      .wr_en(tbl_we), .wr_dest(tbl_dest), .wr_link(tbl_link),
      .lk_dest(f_dest), .lk_link(pref)
   );

   dn_rank #(.PRIO_W(PRIO_W)) u_rank (
      .in_v(in_vld), .prio(f_prio), .ord(ord)
   );

   dn_alloc #(.DEST_W(DEST_W), .NODE_ID(NODE_ID)) u_alloc (
      .in_v(in_vld), .dest(f_dest), .pref(pref), .ord(ord), .cong(cong),
      .out_v(a_v), .out_src(a_src), .out_bump(a_bump),
      .ej_v(a_ej), .ej_src(a_ej_src)
   );

   function automatic logic [PRIO_W-1:0] sat_inc(input logic [PRIO_W-1:0] p);
      return (p == '1) ? p : p + 1'b1;
   endfunction

   for (genvar k = 0; k < LINKS; k++) begin : g_out
      logic [PKT_W-1:0] sp;
      logic [PKT_W-1:0] nx;
      assign sp = in_pkt[a_src[k]];
      assign nx = a_v[k] ? {(a_bump[k] ? sat_inc(sp[PKT_W-1 -: PRIO_W])
                                       : sp[PKT_W-1 -: PRIO_W]),
                            sp[PKT_W-PRIO_W-1:0]}
                         : '0;
      always_ff @(posedge clk) begin
         if (rst) begin
            out_vld[k] <= 1'b0;
            out_pkt[k] <= '0;
         end else begin
            out_vld[k] <= a_v[k];
            out_pkt[k] <= nx;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         eject_vld <= 1'b0;
         eject_pkt <= '0;
      end else begin
         eject_vld <= a_ej;
         eject_pkt <= a_ej ? in_pkt[a_ej_src] : '0;
      end
   end

   // checking state: one non-reset edge has passed
   logic primed;
   always_ff @(posedge clk) begin
      if (rst) primed <= 1'b0;
      else     primed <= 1'b1;
   end

   // R8
   conserve_chk: assert property (@(posedge clk) disable iff (rst)
      primed |-> ($countones(out_vld) + 32'(eject_vld)) == $past($countones(in_vld)));

   // R6
   eject_self_chk: assert property (@(posedge clk) disable iff (rst)
      eject_vld |-> eject_pkt[DATA_W +: DEST_W] == DEST_W'(NODE_ID));

   // R10
   reset_quiet_chk: assert property (@(posedge clk)
      $past(rst) |-> (out_vld == '0) && !eject_vld);

   for (genvar k = 0; k < LINKS; k++) begin : g_rot_chk
      localparam int unsigned SRC = (k + LINKS - 1) % LINKS;
      // R7
      cong_rotate_chk: assert property (@(posedge clk) disable iff (rst)
         (primed && $past(cong) && out_vld[k]) |-> $past(in_vld[SRC]));
   end
endmodule

// File: tb/sim_defl_router.sv
module sim_defl_router;
   localparam int PW = 15;

   typedef struct packed {
      logic [2:0]         iv;
      logic [2:0][PW-1:0] ip;
      logic [2:0]         ov;
      logic [2:0][PW-1:0] op;
      logic               ev;
      logic [PW-1:0]      ep;
   } vec_t;

   // packet hex 0xPDLL: P prio, D dest, LL payload; lanes listed {2,1,0}
   localparam int NV = 11;
   localparam vec_t VEC [NV] = '{
      '{3'b001, {15'h0, 15'h0, 15'h0111}, 3'b010, {15'h0, 15'h0111, 15'h0}, 1'b0, 15'h0},
      '{3'b011, {15'h0, 15'h0333, 15'h0222}, 3'b101, {15'h0222, 15'h0, 15'h0333}, 1'b0, 15'h0},
      '{3'b101, {15'h2455, 15'h0, 15'h0144}, 3'b011, {15'h0, 15'h2455, 15'h1144}, 1'b0, 15'h0},
      '{3'b110, {15'h1877, 15'h1266, 15'h0}, 3'b101, {15'h1266, 15'h0, 15'h2877}, 1'b0, 15'h0},
      '{3'b010, {15'h0, 15'h3588, 15'h0}, 3'b000, {15'h0, 15'h0, 15'h0}, 1'b1, 15'h3588},
      '{3'b101, {15'h4502, 15'h0, 15'h0501}, 3'b001, {15'h0, 15'h0, 15'h1501}, 1'b1, 15'h4502},
      '{3'b011, {15'h0, 15'h7404, 15'h7103}, 3'b011, {15'h0, 15'h7103, 15'h7404}, 1'b0, 15'h0},
      '{3'b111, {15'h7330, 15'h2620, 15'h0110}, 3'b111, {15'h3620, 15'h1110, 15'h7330}, 1'b0, 15'h0},
      '{3'b111, {15'h0560, 15'h1250, 15'h1540}, 3'b101, {15'h2250, 15'h0, 15'h1560}, 1'b1, 15'h1540},
      '{3'b000, {15'h0, 15'h0, 15'h0}, 3'b000, {15'h0, 15'h0, 15'h0}, 1'b0, 15'h0},
      '{3'b011, {15'h0, 15'h0300, 15'h1600}, 3'b011, {15'h0, 15'h1300, 15'h1600}, 1'b0, 15'h0}
   };
   localparam string VTAG [NV] = '{"R1 R2", "R2", "R3 R4", "R3 R4", "R6",
                                   "R6", "R5", "R7 R5", "R7 R6", "R1", "R4"};

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [2:0]        in_vld = '0;
   logic [2:0][PW-1:0] in_pkt = '0;
   logic [2:0]        out_vld;
   logic [2:0][PW-1:0] out_pkt;
   logic              eject_vld;
   logic [PW-1:0]     eject_pkt;
   logic              tbl_we = 1'b0;
   logic [3:0]        tbl_dest = '0;
   logic [1:0]        tbl_link = '0;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   defl_router u0 (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_pkt(in_pkt),
      .out_vld(out_vld), .out_pkt(out_pkt),
      .eject_vld(eject_vld), .eject_pkt(eject_pkt),
      .tbl_we(tbl_we), .tbl_dest(tbl_dest), .tbl_link(tbl_link)
   );

   task automatic check(input string tag, input logic [2:0] ov,
                        input logic [2:0][PW-1:0] op, input logic ev,
                        input logic [PW-1:0] ep);
      n_run++;
      if (out_vld !== ov || out_pkt !== op || eject_vld !== ev || eject_pkt !== ep) begin
         n_fail++;
         $display("FAIL %s: got v=%b p=%h ev=%b ep=%h, want v=%b p=%h ev=%b ep=%h",
                  tag, out_vld, out_pkt, eject_vld, eject_pkt, ov, op, ev, ep);
      end
   endtask

   // drive at negedge, registered result checked at the following negedge
   task automatic send(input logic [2:0] iv, input logic [2:0][PW-1:0] ip);
      in_vld = iv;
      in_pkt = ip;
      @(posedge clk);
      @(negedge clk);
      in_vld = '0;
      in_pkt = '0;
   endtask

   task automatic twrite(input logic [3:0] d, input logic [1:0] l);
      tbl_we = 1'b1; tbl_dest = d; tbl_link = l;
      @(posedge clk);
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   initial begin
      @(negedge clk);
      in_vld = 3'b111;
      in_pkt = {15'h0110, 15'h0120, 15'h0130};
      @(posedge clk);
      @(negedge clk);
      // R10 outputs held at zero in reset
      check("R10 reset", 3'b000, '0, 1'b0, '0);
      in_vld = '0; in_pkt = '0;
      rst = 1'b0;
      for (int d = 0; d < 16; d++) twrite(4'(d), 2'(d % 3));

      for (int v = 0; v < NV; v++) begin
         send(VEC[v].iv, VEC[v].ip);
         check(VTAG[v], VEC[v].ov, VEC[v].op, VEC[v].ev, VEC[v].ep);
      end

      // R9 write of link value 3 is ignored
      twrite(4'd1, 2'd3);
      send(3'b001, {15'h0, 15'h0, 15'h01B1});
      check("R9 ignore", 3'b010, {15'h0, 15'h01B1, 15'h0}, 1'b0, '0);

      // R9 write in same cycle as lookup: old entry, then new
      tbl_we = 1'b1; tbl_dest = 4'd1; tbl_link = 2'd2;
      send(3'b001, {15'h0, 15'h0, 15'h01A1});
      tbl_we = 1'b0;
      check("R9 same cycle", 3'b010, {15'h0, 15'h01A1, 15'h0}, 1'b0, '0);
      send(3'b001, {15'h0, 15'h0, 15'h01A2});
      check("R9 next cycle", 3'b100, {15'h01A2, 15'h0, 15'h0}, 1'b0, '0);

      // R10 reset clears the table back to link 0
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      send(3'b010, {15'h0, 15'h0142, 15'h0});
      check("R10 table", 3'b001, {15'h0, 15'h0, 15'h0142}, 1'b0, '0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got hang, want completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule